// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block runs clause-22 management reads and writes toward an external PHY. Software sees four 32-bit registers behind a small write-strobe and address port. The configuration register holds a clock divisor and an enable bit. The control register holds the target addresses, the operation and an initiate bit. The third register holds outgoing write data and the fourth returns captured read data. Software starts a transaction by writing the control register with the initiate bit set, then polls the ready flag in the same register until it returns to 1.

The management clock is derived from the system clock. Each half period lasts (divisor+1) system clocks, and the clock is parked low while the interface is disabled. The data pin is presented as a split output, output-enable and input, so the pad ring can build the tri-state buffer. Outgoing bits change just after a falling edge of the management clock. Incoming bits are sampled on its rising edge.

The register port is a plain control path with no back-pressure. A control write reaching the block while a transaction is in flight is dropped in full. Its fields are not stored and nothing starts.

Top module: `mdio_master_regs`

## Requirements
- R1: After reset, offset 0x0 (configuration) reads 0x0000001D: the divisor is 29 in bits 5:0 and the enable bit (bit 6) is 0. Offset 0x4 (control) reads 0x00000080, which is the ready bit 7 alone. Offset 0x8 (write data) and offset 0xC (read data) read 0.
- R2: While enabled, the management clock has a period of 2×(divisor+1) system clocks. While the enable bit is 0 it stays low.
- R3: A control write with the initiate bit (bit 11) set while the enable bit is 0 starts nothing. Ready stays 1 and the data output is never enabled.
- R4: A write transaction sends 64 bits, most significant first: 32 ones, 01, opcode 01, PHY address (control bits 28:24), register address (control bits 20:16), turnaround 10, then bits 15:0 of the write-data register.
- R5: A read transaction sends opcode 10 (control bit 15 selects read, bit 14 selects write). It releases the output enable from the first turnaround bit onward and samples the 16 data bits on rising management-clock edges. The result appears in bits 15:0 of offset 0xC, with bits 31:16 reading 0.
- R6: Ready reads 0 from the cycle after an accepted initiate. It returns to 1 exactly three half periods after the rising edge that sampled the last data bit, which is one full management-clock period after that bit's window closed. While ready is 1 the output enable is 0.
- R7: A control write that arrives while ready is 0 is ignored entirely. The running frame is unchanged, the stored control fields keep their old values and no second transaction follows.
- R8: An initiate with both operation bits set, or with neither set, starts nothing, and ready stays 1.
- R9: Reading the control register returns the stored PHY address, register address and both operation bits in their write positions, plus the ready bit 7. The initiate bit reads 0.
- R10: The write-data register keeps bits 15:0 of the last value written and reads 0 in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for reg_addr (combinational) |
| mdc | output | 1 | Management clock toward the PHY |
| mdio_i | input | 1 | Data pin value seen from the pad |
| mdio_o | output | 1 | Data value driven toward the pad |
| mdio_oe | output | 1 | Output enable for the data pad |

## Verification
The bound checker verifies, on every cycle, the interlocks between the register decode and the frame engine. A start is issued only while the interface is enabled and idle. Ready drops on the cycle after a start. The data output is released whenever ready is high. The management clock stays parked while disabled and only rises while enabled. Frame content, the turnaround hand-off, read-data capture, the exact spacing of clock edges and the three-half-period tail before ready returns can only be shown by the bench's scenarios. The bench uses a PHY model that records every driven bit and answers reads, under directed corner cases and random divisors and fields.

// File: rtl/mdiom_pkg.sv
package mdiom_pkg;

  localparam int FRAME_BITS     = 64;
  localparam int PRE_BITS       = 32;
  localparam int DATA_BITS      = 16;
  localparam int ADR_BITS       = 5;
  localparam int RD_RELEASE_IDX = 46;
  localparam int RD_DATA_IDX    = 48;

  localparam logic [3:0] OFS_CFG  = 4'h0;
  localparam logic [3:0] OFS_CTL  = 4'h4;
  localparam logic [3:0] OFS_WDAT = 4'h8;
  localparam logic [3:0] OFS_RDAT = 4'hC;

  localparam int CFG_EN_BIT  = 6;
  localparam int CTL_PHY_LSB = 24;
  localparam int CTL_REG_LSB = 16;
  localparam int CTL_RD_BIT  = 15;
  localparam int CTL_WR_BIT  = 14;
  localparam int CTL_GO_BIT  = 11;
  localparam int CTL_RDY_BIT = 7;

  typedef struct packed {
    logic                 is_rd;
    logic [ADR_BITS-1:0]  phy;
    logic [ADR_BITS-1:0]  regad;
    logic [DATA_BITS-1:0] wdata;
  } mdiom_txn_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ARMED,
    ENG_FRAME,
    ENG_TAIL
  } mdiom_state_e;

endpackage

// File: rtl/mdiom_regs.sv
module mdiom_regs
  import mdiom_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wen,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 eng_ready,
  input  logic                 eng_rd_done,
  input  logic [DATA_BITS-1:0] eng_rd_word,
  output logic [DIV_W-1:0]     cfg_div,
  output logic                 cfg_en,
  output logic                 eng_start,
  output mdiom_txn_t           eng_txn
);

  localparam int CFG_PAD = CFG_EN_BIT - DIV_W;

  logic [DIV_W-1:0]     div_q;
  logic                 en_q;
  logic [ADR_BITS-1:0]  phy_q;
  logic [ADR_BITS-1:0]  regad_q;
  logic                 op_rd_q;
  logic                 op_wr_q;
  logic [DATA_BITS-1:0] wdat_q;
  logic [DATA_BITS-1:0] rdat_q;

  logic hit_cfg, hit_ctl, hit_wdat;
  logic ctl_take;
  logic op_rd_in, op_wr_in, go_in;

  assign hit_cfg  = reg_wen && (reg_addr == ADDR_W'(OFS_CFG));
  assign hit_ctl  = reg_wen && (reg_addr == ADDR_W'(OFS_CTL));
  assign hit_wdat = reg_wen && (reg_addr == ADDR_W'(OFS_WDAT));

  assign op_rd_in = reg_wdata[CTL_RD_BIT];
  assign op_wr_in = reg_wdata[CTL_WR_BIT];
  assign go_in    = reg_wdata[CTL_GO_BIT];

  // a control write is only taken while the engine is idle
  assign ctl_take  = hit_ctl && eng_ready;
  assign eng_start = ctl_take && go_in && en_q && (op_rd_in ^ op_wr_in);

  assign eng_txn.is_rd = op_rd_in;
  assign eng_txn.phy   = reg_wdata[CTL_PHY_LSB +: ADR_BITS];
  assign eng_txn.regad = reg_wdata[CTL_REG_LSB +: ADR_BITS];
  assign eng_txn.wdata = wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
      en_q  <= 1'b0;
    end else if (hit_cfg) begin
      div_q <= reg_wdata[DIV_W-1:0];
      en_q  <= reg_wdata[CFG_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q   <= '0;
      regad_q <= '0;
      op_rd_q <= 1'b0;
      op_wr_q <= 1'b0;
    end else if (ctl_take) begin
      phy_q   <= reg_wdata[CTL_PHY_LSB +: ADR_BITS];
      regad_q <= reg_wdata[CTL_REG_LSB +: ADR_BITS];
      op_rd_q <= op_rd_in;
      op_wr_q <= op_wr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_q <= '0;
    end else if (hit_wdat) begin
      wdat_q <= reg_wdata[DATA_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (eng_rd_done) begin
      rdat_q <= eng_rd_word;
    end
  end

  assign cfg_div = div_q;
  assign cfg_en  = en_q;

  logic [31:0] cfg_view;
  logic [31:0] ctl_view;

  generate
    if (CFG_PAD > 0) begin : g_cfg_pad
      assign cfg_view = {{(31 - CFG_EN_BIT){1'b0}}, en_q, {CFG_PAD{1'b0}}, div_q};
    end else begin : g_cfg_tight
      assign cfg_view = {{(31 - CFG_EN_BIT){1'b0}}, en_q, div_q};
    end
  endgenerate

  always_comb begin
    ctl_view = '0;
    ctl_view[CTL_PHY_LSB +: ADR_BITS] = phy_q;
    ctl_view[CTL_REG_LSB +: ADR_BITS] = regad_q;
    ctl_view[CTL_RD_BIT]  = op_rd_q;
    ctl_view[CTL_WR_BIT]  = op_wr_q;
    ctl_view[CTL_RDY_BIT] = eng_ready;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_CFG)) begin
      reg_rdata = cfg_view;
    end else if (reg_addr == ADDR_W'(OFS_CTL)) begin
      reg_rdata = ctl_view;
    end else if (reg_addr == ADDR_W'(OFS_WDAT)) begin
      reg_rdata = {{(32 - DATA_BITS){1'b0}}, wdat_q};
    end else if (reg_addr == ADDR_W'(OFS_RDAT)) begin
      reg_rdata = {{(32 - DATA_BITS){1'b0}}, rdat_q};
    end
  end

endmodule

// File: rtl/mdiom_clkdiv.sv
module mdiom_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // >= keeps the count bounded if the divisor shrinks mid-phase
  assign wrap     = en && (cnt_q >= div);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdiom_engine.sv
module mdiom_engine
  import mdiom_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  mdiom_txn_t           txn,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 ready,
  output logic                 rd_done,
  output logic [DATA_BITS-1:0] rd_word
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W:0]   REL_IDX  = (IDX_W + 1)'(RD_RELEASE_IDX);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(RD_DATA_IDX);

  mdiom_state_e          st_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  is_rd_q;
  logic [DATA_BITS-1:0]  cap_q;
  logic [IDX_W:0]        nxt_idx;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdiom_txn_t t);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_BITS-1:0] dat;
    op  = t.is_rd ? 2'b10 : 2'b01;
    ta  = 2'b10;
    dat = t.is_rd ? '0 : t.wdata;
    return {{PRE_BITS{1'b1}}, 2'b01, op, t.phy, t.regad, ta, dat};
  endfunction

  assign nxt_idx = {1'b0, idx_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      is_rd_q <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      cap_q   <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (start) begin
            sh_q    <= build_frame(txn);
            is_rd_q <= txn.is_rd;
            idx_q   <= '0;
            st_q    <= ENG_ARMED;
          end
        end
        ENG_ARMED: begin
          if (fall_evt) begin
            mdio_o  <= sh_q[FRAME_BITS-1];
            mdio_oe <= 1'b1;
            sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
            idx_q   <= '0;
            st_q    <= ENG_FRAME;
          end
        end
        ENG_FRAME: begin
          if (fall_evt) begin
            if (idx_q == LAST_IDX) begin
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b0;
              st_q    <= ENG_TAIL;
            end else begin
              idx_q   <= nxt_idx[IDX_W-1:0];
              mdio_o  <= sh_q[FRAME_BITS-1];
              mdio_oe <= !(is_rd_q && (nxt_idx >= REL_IDX));
              sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
            end
          end else if (rise_evt && is_rd_q && (idx_q >= DAT_IDX)) begin
            cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
          end
        end
        ENG_TAIL: begin
          if (fall_evt) begin
            st_q <= ENG_IDLE;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign ready   = (st_q == ENG_IDLE);
  assign rd_done = (st_q == ENG_TAIL) && fall_evt && is_rd_q;
  assign rd_word = cap_q;

endmodule

// File: rtl/mdio_master_regs.sv
module mdio_master_regs
  import mdiom_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);

  logic                 cfg_en;
  logic [DIV_W-1:0]     cfg_div;
  logic                 eng_start;
  mdiom_txn_t           eng_txn;
  logic                 eng_ready;
  logic                 eng_rd_done;
  logic [DATA_BITS-1:0] eng_rd_word;
  logic                 rise_evt;
  logic                 fall_evt;

  mdiom_regs #(
    .ADDR_W (ADDR_W),
    .DIV_W  (DIV_W),
    .DIV_RST(DIV_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_ready  (eng_ready),
    .eng_rd_done(eng_rd_done),
    .eng_rd_word(eng_rd_word),
    .cfg_div    (cfg_div),
    .cfg_en     (cfg_en),
    .eng_start  (eng_start),
    .eng_txn    (eng_txn)
  );

  mdiom_clkdiv #(
    .DIV_W(DIV_W)
  ) u_clkdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_en),
    .div     (cfg_div),
    .mdc     (mdc),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  mdiom_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .txn     (eng_txn),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .ready   (eng_ready),
    .rd_done (eng_rd_done),
    .rd_word (eng_rd_word)
  );

endmodule

// File: rtl/mdiom_checker.sv
module mdiom_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ready,
  input logic en,
  input logic mdc,
  input logic mdio_oe
);

  p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready);

  p_start_when_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> en);

  p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mdio_oe);

  p_mdc_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> !mdc);

  p_mdc_rise_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(en));

endmodule

bind mdio_master_regs mdiom_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (eng_start),
  .ready  (eng_ready),
  .en     (cfg_en),
  .mdc    (mdc),
  .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_master_regs.sv
module tb_mdio_master_regs;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  // PHY model state
  bit          capturing = 1'b0;
  bit          is_read = 1'b0;
  int          idx = 0;
  logic [63:0] seen = '0;
  logic [15:0] phy_val = '0;
  bit          phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  int          last_rise = 0;
  int          rise_gap = 0;
  int          t_last = 0;

  mdio_master_regs dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wen  (reg_wen),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc = cyc + 1;

  assign mdio_i = phy_drv ? phy_bit : 1'b1;

  always @(posedge mdc) begin
    rise_gap  = cyc - last_rise;
    last_rise = cyc;
    if (capturing && (mdio_oe || idx >= 46) && idx < 64) begin
      seen[63 - idx] = mdio_oe ? mdio_o : mdio_i;
      if (idx == 63) t_last = cyc;
      idx = idx + 1;
    end
  end

  always @(negedge mdc) begin
    if (capturing && is_read && idx >= 47 && idx < 64) begin
      phy_drv = 1'b1;
      phy_bit = (idx == 47) ? 1'b0 : phy_val[63 - idx];
    end else begin
      phy_drv = 1'b0;
      phy_bit = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen   = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wen   = 1'b0;
  endtask

  task automatic rnow(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] ctl_word(input bit rd, input bit wrop, input logic [4:0] phy,
                                           input logic [4:0] ra, input bit go);
    return {3'b000, phy, 3'b000, ra, rd, wrop, 2'b00, go, 11'b0};
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d, input int div, input bit inject);
    logic [31:0] v;
    int t_ready;
    int guard;
    string rq;
    rq = rd ? "R5" : "R4";
    phy_val   = d;
    is_read   = rd;
    idx       = 0;
    seen      = '0;
    capturing = 1'b1;
    if (!rd) wr(4'h8, {16'h5A5A, d});
    wr(4'h4, ctl_word(rd, !rd, phy, ra, 1'b1));
    rnow(4'h4, v);
    chk("R6 ready low after initiate", {63'b0, v[7]}, 64'd0);
    if (inject) begin
      wr(4'h4, ctl_word(!rd, rd, ~phy, ~ra, 1'b1));
      rnow(4'h4, v);
      chk("R7 fields kept during busy", {32'b0, v[28:14]}, {32'b0, ctl_word(rd, !rd, phy, ra, 1'b0)} >> 14);
    end
    guard = 0;
    t_ready = 0;
    forever begin
      rnow(4'h4, v);
      if (v[7]) begin
        t_ready = cyc;
        break;
      end
      guard++;
      if (guard > 20000) break;
      @(negedge clk);
    end
    capturing = 1'b0;
    chk("R6 ready returns", {63'b0, v[7]}, 64'd1);
    chk("R6 tail length", 64'(t_ready - t_last), 64'(3 * (div + 1)));
    chk({rq, " bit count"}, 64'(idx), 64'd64);
    chk({rq, " frame"}, seen, exp_frame(rd, phy, ra, d));
    chk("R2 mdc period", 64'(rise_gap), 64'(2 * (div + 1)));
    if (rd) begin
      rnow(4'hC, v);
      chk("R5 read data", {32'b0, v}, {48'b0, d});
    end
    rnow(4'h4, v);
    chk("R9 control readback", {32'b0, v}, {32'b0, ctl_word(rd, !rd, phy, ra, 1'b0) | 32'h80});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad;
    void'($urandom(32'd20240517));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rnow(4'h0, v); chk("R1 config reset", {32'b0, v}, 64'h1D);
    rnow(4'h4, v); chk("R1 control reset", {32'b0, v}, 64'h80);
    rnow(4'h8, v); chk("R1 wdata reset", {32'b0, v}, 64'h0);
    rnow(4'hC, v); chk("R1 rdata reset", {32'b0, v}, 64'h0);

    // R3 initiate while disabled; R2 parked clock
    wr(4'h4, ctl_word(1'b1, 1'b0, 5'h03, 5'h02, 1'b1));
    bad = 0;
    repeat (100) begin
      @(negedge clk);
      rnow(4'h4, v);
      if (mdio_oe || !v[7]) bad++;
      if (mdc) bad += 1000;
    end
    chk("R3 disabled initiate ignored", 64'(bad % 1000), 64'd0);
    chk("R2 mdc parked when disabled", 64'(bad / 1000), 64'd0);

    // R10 write-data register width
    wr(4'h8, 32'hDEAD_BEEF);
    rnow(4'h8, v); chk("R10 wdata readback", {32'b0, v}, 64'h0000_BEEF);

    // enable with default divisor
    wr(4'h0, 32'h40 | 32'd29);
    rnow(4'h0, v); chk("R1 config readback", {32'b0, v}, 64'h5D);
    run_txn(1'b0, 5'h1F, 5'h00, 16'hA5C3, 29, 1'b0);
    run_txn(1'b1, 5'h00, 5'h1F, 16'hFFFF, 29, 1'b0);

    wr(4'h0, 32'h40 | 32'd0);
    run_txn(1'b1, 5'h15, 5'h0A, 16'h0001, 0, 1'b0);

    // R7 control write while busy
    wr(4'h0, 32'h40 | 32'd2);
    run_txn(1'b1, 5'h09, 5'h11, 16'h8421, 2, 1'b1);
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      rnow(4'h4, v);
      if (mdio_oe || !v[7]) bad++;
    end
    chk("R7 no second transaction", 64'(bad), 64'd0);

    // R8 both or neither operation bit
    wr(4'h4, ctl_word(1'b1, 1'b1, 5'h01, 5'h01, 1'b1));
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      rnow(4'h4, v);
      if (mdio_oe || !v[7]) bad++;
    end
    chk("R8 both ops ignored", 64'(bad), 64'd0);
    wr(4'h4, ctl_word(1'b0, 1'b0, 5'h01, 5'h01, 1'b1));
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      rnow(4'h4, v);
      if (mdio_oe || !v[7]) bad++;
    end
    chk("R8 no op ignored", 64'(bad), 64'd0);
    rnow(4'h4, v);
    chk("R9 initiate reads zero", {32'b0, v}, 64'h0101_0080);

    // random transactions
    for (int i = 0; i < 16; i++) begin
      int dv;
      bit rd;
      logic [4:0] phy;
      logic [4:0] ra;
      logic [15:0] d;
      dv  = $urandom_range(0, 5);
      rd  = 1'($urandom_range(0, 1));
      phy = 5'($urandom);
      ra  = 5'($urandom);
      d   = 16'($urandom);
      wr(4'h0, 32'h40 | 32'(dv));
      repeat (4 * (dv + 1)) @(negedge clk);
      run_txn(rd, phy, ra, d, dv, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule